// File: doc/BRIEF.md
# Byte-Wide Serial Port with Bus Register Interface

This block is a serial transmitter and receiver for one byte at a time. It sits behind an 8-bit bus slave port that follows the Wishbone handshake and takes a 12-bit address. A processor writes a byte to the transmit data register. The byte goes into a transmit queue and leaves on `ser_tx` as one start bit, eight data bits with the least significant bit first, and one stop bit. On the input side, frames arriving on `ser_rx` are sampled and assembled into bytes, and each byte is placed in a receive queue. Software takes bytes out of that queue by reading the receive data register.

Bit timing comes from an 8-bit divisor register. A sample tick occurs once every divisor+1 clocks, and each bit lasts 16 ticks. A status register reports whether each queue is empty or full. A level interrupt combines two enable bits with the queue state: one enable covers data waiting in the receive queue, the other covers an empty transmit queue. Registers sit at offsets that are multiples of eight. Every access is acknowledged, and the acknowledge stays high until the master drops its strobe.

Top module: `wb_serial_port`

## Requirements
- R1: A write to offset 0x000 queues the byte. Each queued byte is sent on `ser_tx` as a low start bit, then data bits 0 through 7, then a high stop bit, and the next queued byte follows at once. The line rests high between frames.
- R2: A read of offset 0x008 returns the oldest received byte and removes exactly one byte from the receive queue, even if the strobe is held for several cycles.
- R3: A read of offset 0x010 returns the status word: bit 0 receive queue empty, bit 1 transmit queue empty, bit 2 receive queue full, bit 3 transmit queue full. Bits 7:4 read as 0.
- R4: Offset 0x018 is an 8-bit divisor that can be written and read back. One bit period is 16*(divisor+1) clocks.
- R5: Offset 0x020 holds two interrupt enables: bit 0 for receive data waiting, bit 1 for transmit queue empty. A read returns both bits, with bits 7:2 as 0.
- R6: `intr` is high exactly when (receive enable and receive queue not empty) or (transmit enable and transmit queue empty).
- R7: Reset leaves the divisor at 0, both enables at 0, both queues empty, `bus_ack` low and `ser_tx` high.
- R8: An access is taken when `bus_cyc` and `bus_stb` are both high. The internal acknowledge rises on the next clock edge and stays high while `bus_stb` stays high. `bus_ack` is that acknowledge ANDed with `bus_cyc` and `bus_stb`.
- R9: A read of any unmapped offset returns 0. A write to an unmapped offset, or to offset 0x010 or 0x008, changes no register but is still acknowledged.
- R10: The receiver checks a start bit at the middle of its bit period and drops the frame if the line is high again by then. It takes each data bit at the middle of that bit.
- R11: A byte that completes while the receive queue is full is discarded. A write to 0x000 while the transmit queue is full is dropped.
- R12: Queue depth is the parameter DEPTH, default 64 entries. The full flag is set at exactly DEPTH stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_tx | output | 1 | Serial output, high when idle |
| ser_rx | input | 1 | Serial input |
| intr | output | 1 | Level interrupt |
| bus_adr | input | 12 | Register byte offset |
| bus_wdat | input | 8 | Write data |
| bus_rdat | output | 8 | Read data, valid while bus_ack is high |
| bus_we | input | 1 | Write enable |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Strobe |
| bus_ack | output | 1 | Acknowledge |

## Verification
The handshake assertions assume the master holds `bus_cyc` with `bus_stb` and drops the strobe only after it has seen the acknowledge. The bench's single transfer task drives the bus that way, including the held-strobe case and the case where `bus_cyc` is lowered early. The receiver assertions assume `ser_rx` rests high between frames. The bench either loops `ser_tx` back to the input or drives complete frames and short glitches, always starting from an idle line. The queue-occupancy assertion assumes writes and receptions may arrive at a full queue; the bench sends both queues into overflow on purpose.

// File: rtl/serial_pkg.sv
package serial_pkg;
   localparam logic [11:0] OFS_TXD  = 12'h000;
   localparam logic [11:0] OFS_RXD  = 12'h008;
   localparam logic [11:0] OFS_STAT = 12'h010;
   localparam logic [11:0] OFS_DIV  = 12'h018;
   localparam logic [11:0] OFS_IEN  = 12'h020;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
   typedef enum logic {BUS_IDLE, BUS_HOLD} bus_state_t;
endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr, rptr;
   logic [AW:0]  used;
   logic         do_push, do_pop;

   assign used    = wptr - rptr;
   assign empty   = (used == '0);
   assign full    = (used == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
      end
   end

   // R11 / R12: occupancy never exceeds the configured depth
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
      (wptr - rptr) <= (AW+1)'(DEPTH));
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
   parameter int W   = 8,
   parameter int OSR = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic         have,
   input  logic [W-1:0] din,
   output logic         pop,
   output logic         txo
);
   localparam int CW  = $clog2(OSR);
   localparam int NBW = $clog2(W + 2);

   logic           busy;
   logic [W+1:0]   sh;
   logic [CW-1:0]  ph;
   logic [NBW-1:0] nbits;

   assign pop = !busy && have;
   assign txo = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         sh    <= '1;
         ph    <= '0;
         nbits <= '0;
      end else if (!busy) begin
         if (have) begin
            busy  <= 1'b1;
            sh    <= {1'b1, din, 1'b0};
            ph    <= '0;
            nbits <= '0;
         end
      end else if (tick) begin
         if (ph == CW'(OSR - 1)) begin
            ph <= '0;
            sh <= {1'b1, sh[W+1:1]};
            if (nbits == NBW'(W + 1)) busy <= 1'b0;
            else                      nbits <= nbits + 1'b1;
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end

   // R1: every frame opens with a low start bit
   p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !txo);
   // R1: the last bit driven before going idle is the high stop bit
   p_stop_high_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(txo));
endmodule

// File: rtl/serial_rx.sv
module serial_rx
   import serial_pkg::*;
#(
   parameter int W   = 8,
   parameter int OSR = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic         rxd,
   output logic         push,
   output logic [W-1:0] data
);
   localparam int CW  = $clog2(OSR);
   localparam int NBW = $clog2(W);
   localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);

   rx_state_t      st;
   logic [1:0]     sync;
   logic           rxs;
   logic [CW-1:0]  ph;
   logic [NBW-1:0] nbits;
   logic [W-1:0]   sh;

   assign rxs = sync[1];

   always_ff @(posedge clk) begin
      if (rst) begin
         sync  <= 2'b11;
         st    <= RX_IDLE;
         ph    <= '0;
         nbits <= '0;
         sh    <= '0;
         push  <= 1'b0;
         data  <= '0;
      end else begin
         sync <= {sync[0], rxd};
         push <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: if (!rxs) begin
                  st <= RX_START;
                  ph <= '0;
               end
               RX_START: if (ph == MID) begin
                  ph    <= '0;
                  nbits <= '0;
                  st    <= rxs ? RX_IDLE : RX_DATA;
               end else ph <= ph + 1'b1;
               RX_DATA: if (ph == LAST) begin
                  ph <= '0;
                  sh <= {rxs, sh[W-1:1]};
                  if (nbits == NBW'(W - 1)) st <= RX_STOP;
                  else                      nbits <= nbits + 1'b1;
               end else ph <= ph + 1'b1;
               RX_STOP: if (ph == LAST) begin
                  ph   <= '0;
                  st   <= RX_IDLE;
                  push <= rxs;
                  data <= sh;
               end else ph <= ph + 1'b1;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   // R10: a start bit that is high again at mid-bit returns to idle
   p_start_reject_r10: assert property (@(posedge clk) disable iff (rst)
      (st == RX_START && tick && ph == MID && rxs) |=> st == RX_IDLE);
endmodule

// File: rtl/wb_serial_port.sv
module wb_serial_port
   import serial_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int OSR   = 16
) (
   input  logic        clk,
   input  logic        rst,
   output logic        ser_tx,
   input  logic        ser_rx,
   output logic        intr,
   input  logic [11:0] bus_adr,
   input  logic [7:0]  bus_wdat,
   output logic [7:0]  bus_rdat,
   input  logic        bus_we,
   input  logic        bus_cyc,
   input  logic        bus_stb,
   output logic        bus_ack
);
   localparam int W = 8;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
      $error("OSR must be a power of two of at least 4");
   end

   bus_state_t   bst;
   logic         ack_q;
   logic [7:0]   div_q, tcnt;
   logic [1:0]   ie_q;
   logic         tick;
   logic [7:0]   rd_mux;
   logic         take;
   logic         tx_push, tx_pop, tx_empty, tx_full;
   logic         rx_push, rx_pop, rx_empty, rx_full;
   logic [W-1:0] tx_head, rx_head, rx_byte;

   // sample tick once every div_q+1 clocks
   assign tick = (tcnt >= div_q);
   always_ff @(posedge clk) begin
      if (rst || tick) tcnt <= '0;
      else             tcnt <= tcnt + 1'b1;
   end

   assign take    = (bst == BUS_IDLE) && bus_cyc && bus_stb;
   assign tx_push = take && bus_we && (bus_adr == OFS_TXD);
   assign rx_pop  = take && !bus_we && (bus_adr == OFS_RXD);
   assign bus_ack = ack_q && bus_cyc && bus_stb;
   assign intr    = (ie_q[0] && !rx_empty) || (ie_q[1] && tx_empty);

   always_comb begin
      case (bus_adr)
         OFS_RXD:  rd_mux = rx_head;
         OFS_STAT: rd_mux = {4'b0000, tx_full, rx_full, tx_empty, rx_empty};
         OFS_DIV:  rd_mux = div_q;
         OFS_IEN:  rd_mux = {6'b0, ie_q};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bst      <= BUS_IDLE;
         ack_q    <= 1'b0;
         bus_rdat <= '0;
         div_q    <= '0;
         ie_q     <= '0;
      end else begin
         unique case (bst)
            BUS_IDLE: if (take) begin
               ack_q <= 1'b1;
               bst   <= BUS_HOLD;
               if (bus_we) begin
                  if (bus_adr == OFS_DIV) div_q <= bus_wdat;
                  if (bus_adr == OFS_IEN) ie_q  <= bus_wdat[1:0];
               end else begin
                  bus_rdat <= rd_mux;
               end
            end
            BUS_HOLD: if (!bus_stb) begin
               ack_q <= 1'b0;
               bst   <= BUS_IDLE;
            end
            default: bst <= BUS_IDLE;
         endcase
      end
   end

   serial_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst(rst), .push(tx_push), .wdata(bus_wdat), .pop(tx_pop),
      .rdata(tx_head), .empty(tx_empty), .full(tx_full));

   serial_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
      .rdata(rx_head), .empty(rx_empty), .full(rx_full));

   serial_tx #(.W(W), .OSR(OSR)) u_tx (
      .clk(clk), .rst(rst), .tick(tick), .have(!tx_empty), .din(tx_head),
      .pop(tx_pop), .txo(ser_tx));

   serial_rx #(.W(W), .OSR(OSR)) u_rx (
      .clk(clk), .rst(rst), .tick(tick), .rxd(ser_rx),
      .push(rx_push), .data(rx_byte));

   // R8: acknowledge only rises after a request was presented
   p_ack_after_req_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(ack_q) |-> $past(bus_cyc && bus_stb));
   // R8: acknowledge holds while the strobe stays high
   p_ack_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (ack_q && bus_stb) |=> ack_q);
   // R3: upper status bits are zero on an acknowledged status read
   p_status_upper_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_ack && !bus_we && bus_adr == OFS_STAT) |-> bus_rdat[7:4] == 4'h0);
   // R4: with a non-zero divisor two ticks never fall on adjacent clocks
   p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
      (tick && div_q != 8'd0) |=> (!tick || div_q == 8'd0));
endmodule

// File: tb/tb_wb_serial_port.sv
module tb_wb_serial_port;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ser_tx, ser_rx, intr;
   logic [11:0] bus_adr = '0;
   logic [7:0]  bus_wdat = '0;
   logic [7:0]  bus_rdat;
   logic        bus_we = 1'b0, bus_cyc = 1'b0, bus_stb = 1'b0, bus_ack;
   logic        loop_en = 1'b1;
   logic        rx_man = 1'b1;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   logic held_ok;
   logic ack_nocyc;

   always #2 clk = ~clk;
   assign ser_rx = loop_en ? ser_tx : rx_man;

   wb_serial_port dut (
      .clk(clk), .rst(rst), .ser_tx(ser_tx), .ser_rx(ser_rx), .intr(intr),
      .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
      .bus_we(bus_we), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_ack(bus_ack));

   // {we, offset, write data, expected read data}
   localparam int NV = 12;
   localparam logic [28:0] VEC [NV] = '{
      {1'b1, 12'h018, 8'h5A, 8'h00},   // R4 write divisor
      {1'b0, 12'h018, 8'h00, 8'h5A},   // R4 read back
      {1'b1, 12'h020, 8'hFF, 8'h00},   // R5 write enables
      {1'b0, 12'h020, 8'h00, 8'h03},   // R5 only two bits kept
      {1'b1, 12'h010, 8'hFF, 8'h00},   // R9 write to read-only status
      {1'b0, 12'h010, 8'h00, 8'h03},   // R3 R9 status unchanged
      {1'b1, 12'h030, 8'h77, 8'h00},   // R9 write unmapped
      {1'b0, 12'h030, 8'h00, 8'h00},   // R9 unmapped reads zero
      {1'b0, 12'h018, 8'h00, 8'h5A},   // R9 divisor untouched by stray writes
      {1'b0, 12'hFF8, 8'h00, 8'h00},   // R9 high unmapped offset
      {1'b1, 12'h018, 8'h00, 8'h00},   // R4 divisor back to 0
      {1'b1, 12'h020, 8'h00, 8'h00}    // R5 enables off
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      end
   endtask

   task automatic xfer(input logic we, input logic [11:0] a, input logic [7:0] d,
                       input int hold, output logic [7:0] q);
      int n;
      @(negedge clk);
      bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_adr = a; bus_wdat = d;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!bus_ack && n < 20);
      q = bus_rdat;
      held_ok = bus_ack;
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         if (!bus_ack) held_ok = 1'b0;
      end
      if (hold > 0) begin
         bus_cyc = 1'b0;
         #1 ack_nocyc = bus_ack;
      end
      bus_stb = 1'b0; bus_cyc = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      logic [7:0] q;
      xfer(1'b1, a, d, 0, q);
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] q);
      xfer(1'b0, a, 8'h00, 0, q);
   endtask

   task automatic grab(input int bt, output logic [7:0] b, output logic ok);
      int n = 0;
      while (ser_tx !== 1'b0 && n < 100000) begin
         @(negedge clk);
         n++;
      end
      repeat (bt / 2) @(negedge clk);
      ok = (ser_tx === 1'b0);
      for (int i = 0; i < 8; i++) begin
         repeat (bt) @(negedge clk);
         b[i] = ser_tx;
      end
      repeat (bt) @(negedge clk);
      ok = ok && (ser_tx === 1'b1);
   endtask

   task automatic send_frame(input logic [7:0] b);
      @(negedge clk);
      rx_man = 1'b0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_man = b[i];
         repeat (16) @(negedge clk);
      end
      rx_man = 1'b1;
      repeat (16) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] q, b0, b1;
      logic ok0, ok1;
      int bad;

      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R7 reset state at the ports
      chk("R7 ack after reset", bus_ack, 0);
      chk("R7 ser_tx idle high", ser_tx, 1);
      chk("R7 intr low", intr, 0);
      rd(12'h018, q); chk("R7 divisor zero", q, 8'h00);
      rd(12'h020, q); chk("R7 enables zero", q, 8'h00);
      rd(12'h010, q); chk("R3 R7 status both empty", q, 8'h03);

      // register table walk
      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         v = VEC[i];
         xfer(v[28], v[27:16], v[15:8], 0, q);
         if (!v[28]) chk($sformatf("R3/R4/R5/R9 vector %0d", i), q, v[7:0]);
      end

      // R6 interrupt combinations
      wr(12'h020, 8'h02); @(negedge clk);
      chk("R6 tx-empty enable with empty queue", intr, 1);
      wr(12'h020, 8'h01); @(negedge clk);
      chk("R6 rx enable with empty queue", intr, 0);

      // R1 back-to-back frames, looped back into the receiver
      wr(12'h000, 8'hA5);
      wr(12'h000, 8'h3C);
      grab(16, b0, ok0);
      grab(16, b1, ok1);
      chk("R1 first byte", b0, 8'hA5);
      chk("R1 second byte", b1, 8'h3C);
      chk("R1 start/stop framing", {ok0, ok1}, 2'b11);
      repeat (40) @(negedge clk);
      chk("R6 rx data waiting raises intr", intr, 1);
      rd(12'h008, q); chk("R2 oldest byte first", q, 8'hA5);
      xfer(1'b0, 12'h008, 8'h00, 4, q);
      chk("R2 second byte", q, 8'h3C);
      chk("R8 ack held with strobe", held_ok, 1);
      chk("R8 ack qualified by cyc", ack_nocyc, 0);
      rd(12'h010, q); chk("R2 held read popped once", q, 8'h03);
      @(negedge clk);
      chk("R6 intr clears after drain", intr, 0);
      wr(12'h020, 8'h00);

      // R4 divisor sets bit period
      wr(12'h018, 8'h01);
      wr(12'h000, 8'h81);
      grab(32, b0, ok0);
      chk("R4 byte at divisor 1", b0, 8'h81);
      chk("R4 framing at divisor 1", ok0, 1);
      repeat (80) @(negedge clk);
      rd(12'h008, q); chk("R4 looped byte at divisor 1", q, 8'h81);
      wr(12'h018, 8'h00);

      // R10 glitch rejection and manual frame
      loop_en = 1'b0;
      @(negedge clk);
      rx_man = 1'b0;
      repeat (4) @(negedge clk);
      rx_man = 1'b1;
      repeat (300) @(negedge clk);
      rd(12'h010, q); chk("R10 short low pulse rejected", q, 8'h03);
      send_frame(8'h5E);
      repeat (20) @(negedge clk);
      rd(12'h008, q); chk("R10 mid-bit sampled frame", q, 8'h5E);
      loop_en = 1'b1;

      // R11 R12 receive queue overflow
      for (int i = 0; i < 65; i++) wr(12'h000, 8'(i));
      repeat (11000) @(negedge clk);
      rd(12'h010, q); chk("R12 rx full at depth", q, 8'h06);
      bad = 0;
      for (int i = 0; i < 64; i++) begin
         rd(12'h008, q);
         if (q !== 8'(i)) bad++;
      end
      chk("R11 kept bytes in order", bad, 0);
      rd(12'h010, q); chk("R11 extra byte discarded", q, 8'h03);

      // R11 transmit queue overflow with a slow bit rate
      loop_en = 1'b0;
      wr(12'h018, 8'hFF);
      for (int i = 0; i < 70; i++) wr(12'h000, 8'(i));
      rd(12'h010, q); chk("R11 R12 tx full, writes dropped", q, 8'h09);

      // R7 reset mid-frame
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R7 ser_tx high after reset", ser_tx, 1);
      rd(12'h010, q); chk("R7 queues emptied", q, 8'h03);
      rd(12'h018, q); chk("R7 divisor cleared", q, 8'h00);

      summary();
      $finish;
   end
endmodule